// File: doc/BRIEF.md
# Power-of-Two Prescaled PWM Channel

This block drives one pulse-width-modulated output. A prescaler divides the system clock by two raised to a programmable exponent, and each prescaled tick advances a 10-bit period counter. The output is high for the first programmed number of ticks of each period and low for the rest. Software configures the channel through two 32-bit registers on a simple write-strobe bus with a combinational read port. One register holds the control and mode bits. The other holds the period and the high time.

Several modes shape the waveform. In continuous mode the period repeats while the channel is enabled. In single-pulse mode the channel emits one period and then clears its own enable bit. In synchronized mode, count values written while the channel runs are kept in a shadow copy until the current period ends. Without it they apply at once. Enabling the channel always starts a fresh period with the output high. An illegal count setting keeps the output low.

Top module: `pwm_pow2_chan`

## Requirements
- R1: After reset both registers read zero and `pwm_out` is low.
- R2: The control register sits at offset 0x0. Its fields are: bit 0 enable, bit 4 single-pulse, bit 11 synchronized update, and bits 19:15 prescaler exponent. The count register sits at offset 0x4, with the period in bits 25:16 and the high time in bits 9:0. All other bits read zero. Any other offset reads zero and ignores writes.
- R3: A written exponent above 24 is stored and read back as 24.
- R4: With exponent e, period P and high time H, the output is high for H·2^e clock cycles and then low for (P−H)·2^e cycles, repeating while the channel is enabled.
- R5: After the clock edge that sets enable, the output is high in that same cycle and a new period starts. After the edge that clears enable, the output is low.
- R6: If the period is zero, the high time is zero, or the high time exceeds the period, the output stays low.
- R7: With synchronized update off, a count write takes effect in the cycle after the write edge. The counter keeps its position and wraps once it reaches the new period.
- R8: With synchronized update on, a count write made while running leaves the waveform unchanged until the current period ends. The next period uses the new values.
- R9: In single-pulse mode the channel outputs one period, then clears its enable bit, which reads back as 0. The output then stays low.
- R10: When the high time equals the period, the output stays high continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset within the channel window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
Each bus write lands on the rising edge between two falling edges. The bench sets the strobe on one falling edge and samples on the next. Under that convention the cycle right after the enabling write is period index 0, and its output must already be high. From that index on, the bench compares the output against a computed waveform on every falling edge. In synchronized mode the expected waveform switches at the old period's end. In immediate mode it switches one cycle after the write edge. The single-pulse check expects the output low from the cycle after the last period ends, and reads the enable bit back afterwards.

// File: rtl/pwm_pow2_chan.sv
module pwm_pow2_chan #(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 10,
  parameter int EXP_W   = 5,
  parameter int EXP_MAX = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              pwm_out
);
  localparam int PRE_W     = EXP_MAX + 1;
  localparam int EN_BIT    = 0;
  localparam int SP_BIT    = 4;
  localparam int SY_BIT    = 11;
  localparam int EXP_LSB   = 15;
  localparam int PER_LSB   = 16;
  localparam int HI_LSB    = 0;
  localparam logic [ADDR_W-1:0] CTRL_OFF  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] COUNT_OFF = ADDR_W'(4);
  localparam logic [EXP_W-1:0]  EXP_CAP   = EXP_W'(EXP_MAX);

  logic             en, single, sync;
  logic [EXP_W-1:0] expo;
  logic [CNT_W-1:0] per_r, high_r, act_per, act_high, cnt;
  logic [PRE_W-1:0] pre;

  wire sel_ctrl  = (addr == CTRL_OFF);
  wire sel_count = (addr == COUNT_OFF);
  wire wr_ctrl   = wr_en && sel_ctrl;
  wire wr_count  = wr_en && sel_count;

  wire [EXP_W-1:0] exp_in  = wdata[EXP_LSB +: EXP_W];
  wire [EXP_W-1:0] exp_new = (exp_in > EXP_CAP) ? EXP_CAP : exp_in;

  wire [PRE_W-1:0] pre_lim = (PRE_W'(1) << expo) - PRE_W'(1);
  wire tick = en && (pre == pre_lim);

  wire [CNT_W-1:0] use_per  = (sync && en) ? act_per  : per_r;
  wire [CNT_W-1:0] use_high = (sync && en) ? act_high : high_r;

  wire legal = (use_per != '0) && (use_high != '0) && (use_high <= use_per);
  wire last  = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, use_per};
  wire bnd   = tick && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      single   <= 1'b0;
      sync     <= 1'b0;
      expo     <= '0;
      per_r    <= '0;
      high_r   <= '0;
      act_per  <= '0;
      act_high <= '0;
      cnt      <= '0;
      pre      <= '0;
    end else begin
      if (wr_ctrl) begin
        en     <= wdata[EN_BIT];
        single <= wdata[SP_BIT];
        sync   <= wdata[SY_BIT];
        expo   <= exp_new;
      end else if (bnd && single) begin
        en <= 1'b0;
      end

      if (wr_count) begin
        per_r  <= wdata[PER_LSB +: CNT_W];
        high_r <= wdata[HI_LSB  +: CNT_W];
      end

      if (!en || tick) pre <= '0;
      else             pre <= pre + PRE_W'(1);

      if (!en || bnd) cnt <= '0;
      else if (tick)  cnt <= cnt + CNT_W'(1);

      if (!en || !sync || bnd) begin
        act_per  <= per_r;
        act_high <= high_r;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[EN_BIT]               = en;
      rdata[SP_BIT]               = single;
      rdata[SY_BIT]               = sync;
      rdata[EXP_LSB +: EXP_W]     = expo;
    end else if (sel_count) begin
      rdata[PER_LSB +: CNT_W]     = per_r;
      rdata[HI_LSB  +: CNT_W]     = high_r;
    end
  end

  assign pwm_out = en && legal && (cnt < use_high);
endmodule

module pwm_pow2_chan_chk #(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 10,
  parameter int EXP_W   = 5,
  parameter int EXP_MAX = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              pwm_out,
  input logic              en,
  input logic              single,
  input logic              sync,
  input logic [EXP_W-1:0]  expo,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  use_per,
  input logic [CNT_W-1:0]  use_high,
  input logic [CNT_W-1:0]  act_per,
  input logic [CNT_W-1:0]  act_high
);
  wire period_end = tick && (32'(cnt) + 1 >= 32'(use_per));
  wire bad_cfg    = (use_per == '0) || (use_high == '0) || (use_high > use_per);

  // R5
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !pwm_out);
  // R3
  exp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) 32'(expo) <= EXP_MAX);
  // R6
  illegal_low_chk: assert property (@(posedge clk) disable iff (!rst_n) bad_cfg |-> !pwm_out);
  // R9
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && single && period_end && !(wr_en && addr == '0)) |=> !en);
  // R8
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sync && !period_end && !wr_en) |=> ($stable(act_per) && $stable(act_high)));
endmodule

bind pwm_pow2_chan pwm_pow2_chan_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .pwm_out(pwm_out),
  .en(en), .single(single), .sync(sync), .expo(expo), .tick(tick), .cnt(cnt),
  .use_per(use_per), .use_high(use_high), .act_per(act_per), .act_high(act_high)
);

// File: tb/pwm_pow2_chan_tb.sv
module pwm_pow2_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pwm_pow2_chan u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                       .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = '0;
  endtask

  function automatic bit cont_lvl(input int i, input int p, input int h, input int e);
    return (i % (p << e)) < (h << e);
  endfunction

  function automatic logic [31:0] cnt_word(input int p, input int h);
    return (32'(p) << 16) | 32'(h);
  endfunction

  task automatic watch(input int p, input int h, input int e, input int n, input string req);
    int miss = 0; int first = -1; bit exp_lvl;
    for (int i = 0; i < n; i++) begin
      exp_lvl = cont_lvl(i, p, h, e);
      if (pwm_out !== exp_lvl) begin miss++; if (first < 0) first = i; end
      @(negedge clk);
    end
    check(miss == 0, req, first, 0);
  endtask

  task automatic watch_const(input bit lvl, input int n, input string req);
    int miss = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out !== lvl) miss++;
      @(negedge clk);
    end
    check(miss == 0, req, miss, 0);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(32'd4177);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    rd(12'h0, d); check(d == 0, "R1 ctrl", d, 0);
    rd(12'h4, d); check(d == 0, "R1 count", d, 0);
    check(pwm_out == 1'b0, "R1 out", pwm_out, 0);

    // R2 / R3 field layout and clamp
    wr(12'h4, 32'hFFFF_FFFF);
    rd(12'h4, d); check(d == 32'h03FF_03FF, "R2 count mask", d, 32'h03FF_03FF);
    wr(12'h0, 32'hFFFF_FFFE);
    rd(12'h0, d); check(d == 32'h000C_0810, "R2 R3 ctrl mask", d, 32'h000C_0810);
    wr(12'h8, 32'h0000_0000);
    rd(12'h4, d); check(d == 32'h03FF_03FF, "R2 other offset write", d, 32'h03FF_03FF);
    rd(12'h8, d); check(d == 0, "R2 other offset read", d, 0);
    wr(12'h0, 32'd25 << 15);
    rd(12'h0, d); check(d == (32'd24 << 15), "R3 exp 25", d, 32'd24 << 15);
    wr(12'h0, 32'd24 << 15);
    rd(12'h0, d); check(d == (32'd24 << 15), "R3 exp 24", d, 32'd24 << 15);
    wr(12'h0, 32'd0);

    // R4 / R5 random continuous trials
    for (int t = 0; t < 14; t++) begin
      int p, h, e;
      p = 1 + int'($urandom_range(19));
      h = 1 + int'($urandom_range(p - 1));
      e = int'($urandom_range(3));
      wr(12'h4, cnt_word(p, h));
      wr(12'h0, (32'(e) << 15) | 32'd1);
      check(pwm_out == 1'b1, "R5 starts high", pwm_out, 1);
      watch(p, h, e, 2 * (p << e) + 3, "R4 waveform");
      wr(12'h0, 32'd0);
      check(pwm_out == 1'b0, "R5 low after disable", pwm_out, 0);
    end

    // R4 directed corner: minimum period
    wr(12'h4, cnt_word(2, 1));
    wr(12'h0, 32'd1);
    watch(2, 1, 0, 10, "R4 period 2");
    wr(12'h0, 32'd0);

    // R10
    wr(12'h4, cnt_word(3, 3));
    wr(12'h0, (32'd1 << 15) | 32'd1);
    watch_const(1'b1, 20, "R10 full high");
    wr(12'h0, 32'd0);

    // R6
    wr(12'h4, cnt_word(5, 0));
    wr(12'h0, 32'd1);
    watch_const(1'b0, 16, "R6 high zero");
    wr(12'h4, cnt_word(3, 4));
    watch_const(1'b0, 16, "R6 high over period");
    wr(12'h4, cnt_word(0, 2));
    watch_const(1'b0, 16, "R6 period zero");
    wr(12'h0, 32'd0);

    // R8 synchronized: write at index 3, takes effect at index 10
    wr(12'h4, cnt_word(10, 5));
    wr(12'h0, (32'd1 << 11) | 32'd1);
    begin
      int miss = 0; bit lvl;
      for (int i = 0; i < 3; i++) @(negedge clk);
      wr(12'h4, cnt_word(6, 2));
      for (int i = 4; i < 30; i++) begin
        lvl = (i < 10) ? (i < 5) : (((i - 10) % 6) < 2);
        if (pwm_out !== lvl) miss++;
        @(negedge clk);
      end
      check(miss == 0, "R8 shadow until boundary", miss, 0);
    end
    wr(12'h0, 32'd0);

    // R7 immediate: same write, effect from index 4
    wr(12'h4, cnt_word(10, 5));
    wr(12'h0, 32'd1);
    begin
      int miss = 0; bit lvl;
      for (int i = 0; i < 3; i++) @(negedge clk);
      wr(12'h4, cnt_word(6, 2));
      for (int i = 4; i < 30; i++) begin
        lvl = (i < 6) ? 1'b0 : (((i - 6) % 6) < 2);
        if (pwm_out !== lvl) miss++;
        @(negedge clk);
      end
      check(miss == 0, "R7 immediate update", miss, 0);
    end
    wr(12'h0, 32'd0);

    // R9 single pulse, P=4 H=2 e=1
    wr(12'h4, cnt_word(4, 2));
    wr(12'h0, (32'd1 << 15) | (32'd1 << 4) | 32'd1);
    watch(4, 2, 1, 8, "R9 single period");
    watch_const(1'b0, 20, "R9 stays low");
    rd(12'h0, d);
    check(d == ((32'd1 << 15) | (32'd1 << 4)), "R9 enable cleared", d, (32'd1 << 15) | (32'd1 << 4));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule